// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Slave

This block is a two-wire serial bus slave that gives a bus master read and write access to a 256-entry, byte-wide configuration register array. SCL and SDA are brought into the system clock domain, where the block finds START, repeated START and STOP conditions, checks the 7-bit device address, and then either takes in a register address and data bytes or sends register contents back to the master. SDA is driven open-drain: the block only ever pulls the line low, for acknowledges and for zero bits of read data, through `sda_oe`.

A persistent address pointer holds the location after the last byte read or written. It serves current-address reads, it can be loaded by a write frame that ends in a repeated START (a dummy write that stores nothing), and it wraps from FFh to 00h. Bus traffic is the only data path, so the block has no valid/ready stream interface. Control and status stay on plain pins, and the register contents reach the rest of the chip through the array that this block owns.

Top module: `twi_regfile_slave`

## Requirements
- R1: After reset, register n holds n XOR A5h, the address pointer is 00h, and `sda_oe` is 0.
- R2: The first byte after any START is the device address in bits 7..1 and the direction in bit 0 (1 = read). With address 69h the slave pulls SDA low through the ninth clock as an acknowledge.
- R3: With any other address the slave does not acknowledge. It never drives SDA until the next START or STOP, and the bytes that follow have no effect on the registers or the pointer.
- R4: In a write frame, the second byte loads the pointer. Each complete byte after that is stored at the pointer, the pointer then increments, and the byte is acknowledged.
- R5: The pointer wraps from FFh to 00h on increment, both when writing and when reading.
- R6: A read frame that starts directly after the address returns the register at the pointer, which is one more than the location last read or written.
- R7: A write frame that sends only a register address and is then ended by a repeated START sets the pointer and stores nothing.
- R8: In a read, each byte sent advances the pointer. A master ACK (SDA low on the ninth clock) causes the next register to be sent. A master NACK ends the transfer with SDA released.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Either one aborts the current frame and releases SDA. The slave changes its SDA drive only while SCL is low.
- R10: A data byte cut short by STOP or by a repeated START is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases the line |

## Verification
The assertions check on every cycle that the SDA drive changes only while the synchronized SCL is low, that a START always releases the line, that the idle state never drives SDA, and that every stored byte is acknowledged and moves the pointer by exactly one, including the wrap from FFh to 00h. Only the bench's bus scenarios can show the end-to-end results: the data read back after bursts, current-address and random reads, dummy writes that store nothing, truncated bytes, and that a foreign address leaves the array untouched. The bench compares every read byte against its own register model under both directed and random traffic.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DEPTH  = 1 << BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_REGADR,
    ST_REGACK,
    ST_WRDATA,
    ST_WRACK,
    ST_RDDATA,
    ST_RDACK
  } twi_state_e;

  // Bus events as seen in the system clock domain
  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } line_ev_t;

  function automatic logic [BYTE_W-1:0] reg_default(input int unsigned idx,
                                                    input logic [BYTE_W-1:0] mask);
    return BYTE_W'(idx) ^ mask;
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
  import twi_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output line_ev_t ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;
  logic              sda_s;

  // Idle bus is high, so the pipes reset high to avoid a false event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_comb begin
    ev.scl      = scl_s;
    ev.sda      = sda_s;
    ev.scl_rise = scl_s & ~scl_q;
    ev.scl_fall = ~scl_s & scl_q;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/twi_reg_array.sv
module twi_reg_array
  import twi_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEFAULT_MASK = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reg_default(i, DEFAULT_MASK);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/twi_frame_ctrl.sv
module twi_frame_ctrl
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_ev_t          ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ptr,
  output logic              ptr_inc,
  output logic              sda_oe,
  output twi_state_e        state
);

  localparam int unsigned CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  twi_state_e        st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic              rw;
  logic              mack;
  logic              oe;
  logic              byte_done;
  logic              rx_state;

  assign byte_done = (bitcnt == FULL);
  assign rx_state  = (st == ST_DEVADR) || (st == ST_REGADR) || (st == ST_WRDATA);

  always_comb begin
    wr_en   = (st == ST_WRDATA) && ev.scl_fall && byte_done;
    wr_data = shreg;
    ptr_inc = wr_en || ((st == ST_RDDATA) && ev.scl_fall && (bitcnt == LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txreg  <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      oe     <= 1'b0;
    end else if (ev.start) begin
      st     <= ST_DEVADR;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else if (ev.stop) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      oe     <= 1'b0;
    end else if (rx_state) begin
      if (ev.scl_rise && !byte_done) begin
        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
        bitcnt <= bitcnt + 1'b1;
      end else if (ev.scl_fall && byte_done) begin
        bitcnt <= '0;
        unique case (st)
          ST_DEVADR: begin
            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
              rw <= shreg[0];
              oe <= 1'b1;
              st <= ST_DEVACK;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_REGADR: begin
            ptr <= shreg;
            oe  <= 1'b1;
            st  <= ST_REGACK;
          end
          default: begin
            ptr <= ptr + 1'b1;
            oe  <= 1'b1;
            st  <= ST_WRACK;
          end
        endcase
      end
    end else begin
      case (st)
        ST_DEVACK, ST_REGACK, ST_WRACK: begin
          if (ev.scl_fall) begin
            bitcnt <= '0;
            if ((st == ST_DEVACK) && rw) begin
              txreg <= rd_data;
              oe    <= ~rd_data[BYTE_W-1];
              st    <= ST_RDDATA;
            end else begin
              oe <= 1'b0;
              st <= (st == ST_DEVACK) ? ST_REGADR : ST_WRDATA;
            end
          end
        end
        ST_RDDATA: begin
          if (ev.scl_fall) begin
            if (bitcnt == LAST) begin
              oe     <= 1'b0;
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              st     <= ST_RDACK;
            end else begin
              txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              oe     <= ~txreg[BYTE_W-2];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_RDACK: begin
          if (ev.scl_rise) begin
            mack <= ~ev.sda;
          end else if (ev.scl_fall) begin
            if (mack) begin
              txreg  <= rd_data;
              oe     <= ~rd_data[BYTE_W-1];
              bitcnt <= '0;
              st     <= ST_RDDATA;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe;
  assign state  = st;

endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave
  import twi_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR     = 7'h69,
  parameter int unsigned       SYNC_STAGES  = 2,
  parameter logic [BYTE_W-1:0] DEFAULT_MASK = 8'hA5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  line_ev_t          line_ev;
  logic              scl_sync;
  logic              start_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-1:0] rd_data;
  logic              ptr_inc;
  twi_state_e        fsm_state;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev    (line_ev)
  );

  twi_frame_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (line_ev),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ptr     (ptr),
    .ptr_inc (ptr_inc),
    .sda_oe  (sda_oe),
    .state   (fsm_state)
  );

  twi_reg_array #(.DEFAULT_MASK(DEFAULT_MASK)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (ptr),
    .wdata (wr_data),
    .raddr (ptr),
    .rdata (rd_data)
  );

  assign scl_sync  = line_ev.scl;
  assign start_det = line_ev.start;

endmodule

// File: rtl/twi_regfile_slave_chk.sv
module twi_regfile_slave_chk
  import twi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_sync,
  input logic              start_det,
  input logic              sda_oe,
  input logic              ptr_inc,
  input logic              wr_en,
  input twi_state_e        state,
  input logic [BYTE_W-1:0] ptr
);

  assert_release_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_drive_changes_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_sync);

  assert_idle_never_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  assert_store_is_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sda_oe && (state == ST_WRACK)));

  assert_ptr_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc |=> (ptr == $past(ptr) + 8'd1));

  assert_ptr_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && (ptr == 8'hFF)) |=> (ptr == 8'h00));

endmodule

bind twi_regfile_slave twi_regfile_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_sync  (scl_sync),
  .start_det (start_det),
  .sda_oe    (sda_oe),
  .ptr_inc   (ptr_inc),
  .wr_en     (wr_en),
  .state     (fsm_state),
  .ptr       (ptr)
);

// File: tb/tb_twi_regfile_slave.sv
module tb_twi_regfile_slave;

  localparam int         Q   = 6;
  localparam logic [6:0] DEV = 7'h69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;

  assign sda_bus = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  twi_regfile_slave dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (m_scl),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  int   oe_seen = 0;
  bit   watch = 1'b0;
  logic [7:0] model [256];
  logic [7:0] mptr;
  logic [7:0] wbuf [8];

  always @(negedge clk) if (watch && sda_oe) oe_seen++;

  function automatic logic [7:0] dflt(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda = 1'b1; q(); q();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; q();
    m_scl = 1'b1; q(); q();
    m_scl = 1'b0; q();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    b = sda_bus; q();
    m_scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit give_ack);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      v = {v[6:0], b};
    end
    put_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  // R4: register address then n data bytes from wbuf
  task automatic write_burst(input logic [7:0] ra, input int n, input string req);
    logic ack;
    logic [7:0] a;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check("R2", ack, 1, "device address ack on write");
    send_byte(ra, ack);
    check(req, ack, 1, "register address ack");
    a = ra;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check(req, ack, 1, "data byte ack");
      model[a] = wbuf[i];
      a = a + 8'd1;
    end
    mptr = a;
    bus_stop();
  endtask

  // R6/R7/R8: optional dummy write to set the pointer, then n bytes read
  task automatic read_burst(input bit set_ptr, input logic [7:0] ra, input int n,
                            input string req);
    logic ack;
    logic [7:0] v;
    bus_start();
    if (set_ptr) begin
      send_byte({DEV, 1'b0}, ack);
      check("R7", ack, 1, "dummy write device ack");
      send_byte(ra, ack);
      check("R7", ack, 1, "dummy write register ack");
      bus_rstart();
      mptr = ra;
    end
    send_byte({DEV, 1'b1}, ack);
    check("R2", ack, 1, "device address ack on read");
    for (int i = 0; i < n; i++) begin
      recv_byte(v, i < n - 1);
      check(req, v, model[mptr], "read data");
      mptr = mptr + 8'd1;
    end
    q();
    check("R8", sda_oe, 0, "SDA released after master NACK");
    bus_stop();
  endtask

  initial begin
    int unsigned seed;
    logic ack;
    logic [7:0] v;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) model[i] = dflt(i);
    mptr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state, SDA released and default contents at pointer 00h
    check("R1", sda_oe, 0, "sda_oe after reset");
    read_burst(1'b0, 8'h00, 2, "R1");

    // R4/R8: burst write then sequential random read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_burst(8'h10, 3, "R4");
    read_burst(1'b1, 8'h10, 3, "R8");

    // R5: write wraps through FFh to 00h; R6: current read after it
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    write_burst(8'hFE, 3, "R5");
    check("R5", model[8'h00], 8'hC3, "model wrap sanity");
    read_burst(1'b0, 8'h00, 1, "R6");
    read_burst(1'b1, 8'hFF, 2, "R5");

    // R7: dummy write must not store; read back via random read
    read_burst(1'b1, 8'h20, 1, "R7");
    check("R7", model[8'h20], dflt(8'h20), "model unchanged at 20h");

    // R3: foreign address is not acknowledged and never driven
    oe_seen = 0;
    watch = 1'b1;
    bus_start();
    send_byte({7'h3C, 1'b0}, ack);
    check("R3", ack, 0, "foreign write address NACK");
    send_byte(8'h40, ack);
    send_byte(8'h77, ack);
    bus_stop();
    bus_start();
    send_byte({7'h68, 1'b1}, ack);
    check("R3", ack, 0, "foreign read address NACK");
    recv_byte(v, 1'b0);
    bus_stop();
    watch = 1'b0;
    check("R3", oe_seen, 0, "cycles with SDA driven during foreign traffic");
    read_burst(1'b0, 8'h00, 1, "R3");
    read_burst(1'b1, 8'h40, 1, "R3");

    // R10: data byte cut by STOP is not stored, pointer stays at 30h
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h30, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    mptr = 8'h30;
    read_burst(1'b0, 8'h30, 1, "R10");

    // R9: repeated START in the middle of a data byte aborts it
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h50, ack);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_rstart();
    check("R9", sda_oe, 0, "SDA released after repeated START");
    send_byte({DEV, 1'b1}, ack);
    check("R9", ack, 1, "ack after repeated START");
    recv_byte(v, 1'b0);
    check("R9", v, dflt(8'h50), "aborted byte not stored at 50h");
    bus_stop();
    mptr = 8'h51;

    // Random traffic mixed over writes, random reads and current reads
    for (int it = 0; it < 24; it++) begin
      int unsigned kind;
      int n;
      logic [7:0] ra;
      kind = $urandom % 3;
      n = 1 + int'($urandom % 4);
      ra = 8'($urandom);
      if (kind == 0) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        write_burst(ra, n, "R4");
      end else if (kind == 1) begin
        read_burst(1'b1, ra, n, "R8");
      end else begin
        read_burst(1'b0, 8'h00, n, "R6");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule